// File: doc/BRIEF.md
# Byte-Adjustable Seconds Counter

This block keeps a 32-bit count of elapsed seconds. The count advances once for every 32768 rising edges of a slow crystal oscillator. The oscillator input is asynchronous to the system clock. It is brought into the system clock domain with a flop synchronizer and turned into a single-cycle step by edge detection. A 15-bit prescaler then divides those steps down to a one-second tick.

The host reaches the count through a byte-wide port with a two-bit offset. Reads at the four offsets return the count one byte at a time, most significant byte first. Writes at offset 0 clear the count. Writes at offset 1 carry four active-low strobes, one per counter byte. Each strobe adds one to its byte, and the carry ripples upward just as it does for a normal tick.

One interlock is reproduced on purpose. A strobe for a byte is refused while bit 7 of the byte just below it is set. That byte can then only move by carry from below. The count keeps running while software adjusts it. Software must also cope with torn multi-byte reads on its own.

Top module: `sec_tally`

## Requirements
- R1: After reset the count is zero, every read offset returns 0x00, and the oscillator status output is 0.
- R2: Read offset 0 returns count bits 31..24, offset 1 bits 23..16, offset 2 bits 15..8 and offset 3 bits 7..0.
- R3: A write at offset 0 sets the count to zero whatever the written data.
- R4: A write at offset 1 adds one to byte k (k = 0 for bits 7..0 up to k = 3 for bits 31..24) for every data bit k in 3..0 that is 0. Data bits 7..4 have no effect. Writes at offsets 2 and 3 have no effect on the count.
- R5: The strobe for byte k (k >= 1) is ignored when bit 8k-1 of the count, sampled before the write, is 1. Other strobes in the same write still apply.
- R6: An increment from a strobe carries into the higher bytes. A carry out of bit 31 is dropped, so the count wraps to zero.
- R7: The count increases by one after every 2^PRESCALE_W rising edges of the oscillator input. With the default PRESCALE_W = 15 this is 32768 edges.
- R8: A write at offset 0 also clears the prescaler, so the next tick needs a full 2^PRESCALE_W further edges.
- R9: When a tick and a strobe write take effect in the same clock cycle, both increments are applied.
- R10: The oscillator status output follows the level of the oscillator input after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Raw 32768 Hz oscillator level, asynchronous |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 2 | Register offset for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Selected count byte |
| osc_lvl_o | output | 1 | Synchronized oscillator level |

## Verification
The one-second tick and a byte-strobe write can land in the same clock cycle. Both of them then feed the single adder. The bench provokes this by counting oscillator edges up to the last one before a tick. It then issues the strobe write in the cycle in which the synchronized edge reaches the prescaler. The result is judged by reading back a count of exactly two.

// File: rtl/sectally_pkg.sv
package sectally_pkg;
  localparam int unsigned BYTE_W = 8;

  // Register offsets with a write meaning
  localparam logic [1:0] OFF_CLEAR = 2'd0;
  localparam logic [1:0] OFF_BUMP  = 2'd1;
endpackage

// File: rtl/sectally_sync.sv
module sectally_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sectally_prescale.sv
module sectally_prescale #(
  parameter int unsigned WIDTH = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [WIDTH-1:0] div_q;
  logic [WIDTH-1:0] div_d;

  always_comb begin
    div_d = div_q;
    if (clr_i)       div_d = '0;
    else if (step_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign tick_o = step_i & (&div_q) & ~clr_i;
endmodule

// File: rtl/sectally_core.sv
module sectally_core
  import sectally_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned CW   = BYTES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             bump_we_i,
  input  logic [BYTES-1:0] bump_n_i,
  output logic [CW-1:0]    count_o
);
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_d;
  logic [CW-1:0]    add_v;
  logic [BYTES-1:0] bump_en;

  // Per-byte strobe enable, gated by the MSB of the next lower byte
  for (genvar i = 0; i < BYTES; i++) begin : g_en
    if (i == 0) begin : g_low
      assign bump_en[i] = bump_we_i & ~bump_n_i[i];
    end else begin : g_up
      assign bump_en[i] = bump_we_i & ~bump_n_i[i] & ~cnt_q[i*BYTE_W-1];
    end
  end

  always_comb begin
    add_v = '0;
    for (int i = 0; i < BYTES; i++) begin
      add_v[i*BYTE_W +: BYTE_W] = {{(BYTE_W-1){1'b0}}, bump_en[i]};
    end
  end

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + add_v + {{(CW-1){1'b0}}, tick_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sec_tally.sv
module sec_tally
  import sectally_pkg::*;
#(
  parameter int unsigned PRESCALE_W  = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       osc_lvl_o
);
  localparam int unsigned BYTES = 4;
  localparam int unsigned CW    = BYTES * BYTE_W;

  logic          osc_rise;
  logic          sec_tick;
  logic          clr_wr;
  logic          bump_wr;
  logic [CW-1:0] count;

  assign clr_wr  = wr_en_i & (addr_i == OFF_CLEAR);
  assign bump_wr = wr_en_i & (addr_i == OFF_BUMP);

  sectally_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (osc_i),
    .level_o (osc_lvl_o),
    .rise_o  (osc_rise)
  );

  sectally_prescale #(.WIDTH(PRESCALE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (osc_rise),
    .clr_i  (clr_wr),
    .tick_o (sec_tick)
  );

  sectally_core #(.BYTES(BYTES)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_tick),
    .clr_i     (clr_wr),
    .bump_we_i (bump_wr),
    .bump_n_i  (wdata_i[BYTES-1:0]),
    .count_o   (count)
  );

  // Offset 0 holds the most significant byte
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (addr_i == 2'(BYTES - 1 - i)) rdata_o = count[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sec_tally_chk.sv
module sec_tally_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        tick,
  input logic [31:0] count
);
  // R3
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> (count == 32'd0));

  // R4
  upper_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1] && !tick) |=> (count == $past(count)));

  // R5
  interlock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1 && wdata_i[3:0] == 4'b1101 && !tick && count[7])
      |=> (count == $past(count)));

  // R7
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && tick) |=> (count == $past(count) + 32'd1));

  // R9
  tick_and_bump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1 && wdata_i[3:0] == 4'b1110 && tick)
      |=> (count == $past(count) + 32'd2));
endmodule

bind sec_tally sec_tally_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick    (sec_tick),
  .count   (count)
);

// File: tb/sim_sec_tally.sv
module sim_sec_tally;
  logic       clk;
  logic       rst_n;
  logic       osc;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       osc_lvl;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Small prescaler so ticks arrive every 8 oscillator edges
  sec_tally #(.PRESCALE_W(3)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .osc_i     (osc),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .osc_lvl_o (osc_lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {bump data, expected count}, applied one after another from zero
  localparam logic [39:0] VEC [6] = '{
    {8'hFE, 32'h0000_0001},
    {8'hF0, 32'h0101_0102},
    {8'hF7, 32'h0201_0102},
    {8'hFD, 32'h0201_0202},
    {8'h0F, 32'h0201_0202},
    {8'hFB, 32'h0202_0202}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
  endtask

  task automatic read32(output logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      addr = 2'(k);
      #1;
      v[31-8*k -: 8] = rdata;
    end
    @(negedge clk);
    addr = 2'd0;
  endtask

  task automatic osc_pulse();
    @(negedge clk); osc = 1'b1;
    repeat (4) @(negedge clk);
    osc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; osc = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read32(v);
    check("R1 count after reset", v, 32'h0);
    check("R1 osc status after reset", {31'b0, osc_lvl}, 32'h0);

    // R4 R5 vector table
    for (int i = 0; i < 6; i++) begin
      write(2'd1, VEC[i][39:32]);
      read32(v);
      check($sformatf("R4 vector %0d", i), v, VEC[i][31:0]);
    end

    // R4 writes at offsets 2 and 3 do nothing
    write(2'd2, 8'h00);
    write(2'd3, 8'h00);
    read32(v);
    check("R4 offsets 2 and 3 ignored", v, 32'h0202_0202);

    // R3 clear with arbitrary data
    write(2'd0, 8'hA5);
    read32(v);
    check("R3 clear", v, 32'h0);

    // R2 byte order, bytes made distinct
    write(2'd1, 8'hFE);
    repeat (2) write(2'd1, 8'hFD);
    repeat (3) write(2'd1, 8'hFB);
    repeat (4) write(2'd1, 8'hF7);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); addr = 2'(k); #1;
      check($sformatf("R2 offset %0d", k), {24'b0, rdata}, 32'(4 - k));
    end

    // R5 interlock on lower byte MSB
    write(2'd0, 8'h00);
    repeat (128) write(2'd1, 8'hFE);
    write(2'd1, 8'hFD);
    read32(v);
    check("R5 byte1 strobe refused", v, 32'h0000_0080);
    write(2'd1, 8'hFE);
    write(2'd1, 8'hF0);
    read32(v);
    check("R5 mixed strobes", v, 32'h0101_0082);

    // R6 carry from a strobe and wrap at the top
    write(2'd0, 8'h00);
    repeat (256) write(2'd1, 8'hFE);
    read32(v);
    check("R6 carry into byte1", v, 32'h0000_0100);
    write(2'd0, 8'h00);
    repeat (256) write(2'd1, 8'hF7);
    read32(v);
    check("R6 wrap past bit 31", v, 32'h0);

    // R10 oscillator level
    @(negedge clk); osc = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 osc high", {31'b0, osc_lvl}, 32'h1);
    osc = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 osc low", {31'b0, osc_lvl}, 32'h0);

    // R7 tick every 8 edges
    write(2'd0, 8'h00);
    repeat (7) osc_pulse();
    read32(v);
    check("R7 before eighth edge", v, 32'h0);
    osc_pulse();
    read32(v);
    check("R7 after eighth edge", v, 32'h1);

    // R8 prescaler cleared by the clear write
    write(2'd0, 8'h00);
    repeat (5) osc_pulse();
    write(2'd0, 8'h00);
    repeat (5) osc_pulse();
    read32(v);
    check("R8 prescaler restarted", v, 32'h0);
    repeat (3) osc_pulse();
    read32(v);
    check("R8 tick after full period", v, 32'h1);

    // R9 tick and strobe in the same cycle
    write(2'd0, 8'h00);
    repeat (7) osc_pulse();
    @(negedge clk); osc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'hFE;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    osc = 1'b0;
    repeat (4) @(negedge clk);
    read32(v);
    check("R9 tick plus strobe", v, 32'h2);

    finish_run();
  end
endmodule